// File: doc/BRIEF.md
# Graphics Aperture Address Remapper

The remapper turns bus addresses that land inside a graphics aperture into system physical addresses. The aperture is a 256 MB window chosen by the top four address bits. Inside that window, address bits [27:12] index a translation table kept in system memory, with one 32-bit word for each 4 KB page. Bits [11:0] pass through to the physical address unchanged. An eight-entry, fully associative translation cache keeps recently used table words, so that repeated accesses to a page need no memory read.

Software sets up the block through three write-only configuration registers: the aperture window, the table location with its page count, and a control word. A control write can turn translation on or off, drop every cached entry, or reset the walk state. The block also watches the order of control writes. It reports when a complete flush sequence or a shutdown sequence has been issued. A lookup that misses the cache issues a single read on the memory port and holds it until data returns. Lookups that fall outside the window, past the table end, or onto an entry marked invalid come back as faults.

Top module: `aperture_remap`

## Requirements
- R1: After reset, lk_ready is 1; rsp_valid, mem_req, flush_done and shut_done are 0; and translation is disabled.
- R2: While the enable bit (control bit 8) is 0, an accepted lookup returns rsp_fault=1 on the next cycle and raises no mem_req.
- R3: A lookup whose address bits [31:28] differ from bits [31:28] of the aperture register (cfg_sel=0) faults on the next cycle with no memory read. The lower 28 bits of that register are ignored.
- R4: The table register (cfg_sel=1) holds the page-aligned table address in bits [31:12] and the page count in bits [11:0]. A lookup whose index (address bits [27:12]) is equal to or greater than the count faults on the next cycle with no read. An index of count-1 is translated.
- R5: On a cache miss, mem_req rises the cycle after the lookup is accepted, with mem_addr = table base + 4*index. mem_req stays high with a stable address until the cycle in which mem_rvalid is 1.
- R6: The memory word is little-endian on a big-endian bus: value = {rdata[7:0], rdata[15:8], rdata[23:16], rdata[31:24]}. When value bit 0 is 1, the response arrives the cycle after mem_rvalid with rsp_paddr = {value[31:12], address[11:0]} and rsp_fault=0.
- R7: A fetched word with value bit 0 clear produces a fault and is not cached, so the next lookup of that page reads memory again.
- R8: A lookup that hits the cache responds on the next cycle with the cached page and no mem_req.
- R9: The cache holds 8 entries and replaces them round-robin, starting at entry 0 after reset or an invalidate. The ninth distinct fill evicts the first page and keeps the second.
- R10: A control write (cfg_sel=2) with bit 0 set clears every cached entry in that cycle, and resets the replacement pointer.
- R11: A control write with bit 16 set also clears the cache. If a fetch is pending, it aborts that fetch: mem_req drops and a fault response comes the next cycle. A later mem_rvalid produces no response.
- R12: flush_done pulses for one cycle after the fourth of these consecutive control writes: enable|invalidate, enable, enable|reset, enable. Any other order does not pulse it.
- R13: shut_done pulses for one cycle after a control write of reset alone that directly follows enable|invalidate. Translation is then disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 aperture, 1 table, 2 control |
| cfg_wdata | input | 32 | Configuration write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Aperture bus address to translate |
| lk_ready | output | 1 | Block can accept a lookup (no fetch pending) |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| mem_req | output | 1 | Table-word read request |
| mem_addr | output | 32 | Address of the table word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Raw table word as seen on the bus |
| flush_done | output | 1 | Full flush sequence recognised |
| shut_done | output | 1 | Shutdown sequence recognised |

## Verification
The bench uses the default parameters: 32-bit addresses, a 4-bit aperture select, 4 KB pages with a 12-bit page count, and eight cache entries. The page count is set to ten, so both the last legal index and the first out-of-range index can be tested. That table also has room for nine distinct valid pages, which is enough to wrap the round-robin pointer and show which entry gets evicted. The memory model changes its read latency between lookups, so the bench can see that a request is held across several cycles and can abort a pending fetch.

// File: rtl/aprm_pkg.sv
// Shared constants and helpers for the aperture remapper.
// Assumes a 32-bit configuration data word.
package aprm_pkg;

    localparam int CFG_W = 32;

    // Register select codes on cfg_sel
    localparam logic [1:0] SEL_APER = 2'd0;
    localparam logic [1:0] SEL_TABLE = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    // Control word bit positions
    localparam int CB_INV = 0;
    localparam int CB_EN = 8;
    localparam int CB_RST = 16;

    // Control command codes after masking to the three meaningful bits
    typedef enum logic [2:0] {
        CMD_NONE = 3'b000,
        CMD_INV = 3'b001,
        CMD_EN = 3'b010,
        CMD_RST = 3'b100,
        CMD_EN_INV = 3'b011,
        CMD_EN_RST = 3'b110
    } ctrl_cmd_e;

    // Progress through a recognised control-write sequence
    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_INV_SEEN,
        SQ_EN1_SEEN,
        SQ_RST_SEEN
    } seq_state_e;

    // Reorder a little-endian word received on a big-endian bus
    function automatic logic [31:0] le_word(input logic [31:0] raw);
        return {raw[7:0], raw[15:8], raw[23:16], raw[31:24]};
    endfunction

endpackage

// File: rtl/aprm_cfg.sv
// Configuration registers and control-write sequence tracker.
// Holds the aperture select, the table base and count, and the enable bit.
// Issues single-cycle invalidate and reset commands on control writes.
// Recognises the full flush and shutdown write orders.
// Assumes writes are single-cycle strobes. There is no read path.
module aprm_cfg
    import aprm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int APER_BITS = 4,
    parameter int PAGE_SHIFT = 12
) (
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic [1:0] cfg_sel,
    input logic [CFG_W-1:0] cfg_wdata,
    output logic [APER_BITS-1:0] aper_sel_o,
    output logic [ADDR_W-PAGE_SHIFT-1:0] tbl_ppn_o,
    output logic [PAGE_SHIFT-1:0] page_cnt_o,
    output logic en_o,
    output logic inv_cmd_o,
    output logic rst_cmd_o,
    output logic flush_done_o,
    output logic shut_done_o
);

    localparam int PPN_W = ADDR_W - PAGE_SHIFT;

    logic ctrl_wr;
    logic [2:0] cmd;
    logic [APER_BITS-1:0] aper_q;
    logic [ADDR_W-1:0] tbl_q;
    logic en_q;
    seq_state_e seq_q, seq_d;
    logic flush_d, shut_d, flush_q, shut_q;
    logic unused_wbits;

    // Decode the control write and its masked command
    always_comb begin
        ctrl_wr = cfg_wr && (cfg_sel == SEL_CTRL);
        cmd = {cfg_wdata[CB_RST], cfg_wdata[CB_EN], cfg_wdata[CB_INV]};
    end

    assign inv_cmd_o = ctrl_wr && cfg_wdata[CB_INV];
    assign rst_cmd_o = ctrl_wr && cfg_wdata[CB_RST];
    assign unused_wbits = ^cfg_wdata;

    // Store the configuration registers on their writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aper_q <= '0;
            tbl_q <= '0;
            en_q <= 1'b0;
        end else if (cfg_wr) begin
            if (cfg_sel == SEL_APER) aper_q <= cfg_wdata[CFG_W-1 -: APER_BITS];
            if (cfg_sel == SEL_TABLE) tbl_q <= cfg_wdata[ADDR_W-1:0];
            if (cfg_sel == SEL_CTRL) en_q <= cfg_wdata[CB_EN];
        end
    end

    // Next state of the sequence tracker for each control write
    always_comb begin
        seq_d = seq_q;
        flush_d = 1'b0;
        shut_d = 1'b0;
        if (ctrl_wr) begin
            if (cmd == CMD_EN_INV) begin
                seq_d = SQ_INV_SEEN;
            end else begin
                seq_d = SQ_IDLE;
                unique case (seq_q)
                    SQ_INV_SEEN: begin
                        if (cmd == CMD_EN) seq_d = SQ_EN1_SEEN;
                        else if (cmd == CMD_RST) shut_d = 1'b1;
                    end
                    SQ_EN1_SEEN: if (cmd == CMD_EN_RST) seq_d = SQ_RST_SEEN;
                    SQ_RST_SEEN: if (cmd == CMD_EN) flush_d = 1'b1;
                    default: seq_d = SQ_IDLE;
                endcase
            end
        end
    end

    // Register the tracker state and its completion pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SQ_IDLE;
            flush_q <= 1'b0;
            shut_q <= 1'b0;
        end else begin
            seq_q <= seq_d;
            flush_q <= flush_d;
            shut_q <= shut_d;
        end
    end

    assign aper_sel_o = aper_q;
    assign tbl_ppn_o = tbl_q[ADDR_W-1 -: PPN_W];
    assign page_cnt_o = tbl_q[PAGE_SHIFT-1:0];
    assign en_o = en_q;
    assign flush_done_o = flush_q;
    assign shut_done_o = shut_q;

    // R12/R13: the two completion pulses never coincide
    a_r12_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_q && shut_q));

    // R12: a flush pulse lasts one cycle
    a_r12_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q |=> !flush_q);

    // R13: after shutdown is recognised, translation is off
    a_r13_shut_disables: assert property (@(posedge clk) disable iff (!rst_n)
        shut_q |-> !en_q);

endmodule

// File: rtl/aprm_tcache.sv
// Fully associative translation cache with round-robin replacement.
// Matches a page index against every entry in parallel.
// Fills at the replacement pointer. Invalidate clears all valid bits and
// the pointer in one cycle, and takes priority over a fill.
// Assumes the caller never fills a tag that already hits.
module aprm_tcache #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 16,
    parameter int DATA_W = 20
) (
    input logic clk,
    input logic rst_n,
    input logic [TAG_W-1:0] look_tag_i,
    output logic hit_o,
    output logic [DATA_W-1:0] hit_data_o,
    input logic fill_i,
    input logic [TAG_W-1:0] fill_tag_i,
    input logic [DATA_W-1:0] fill_data_i,
    input logic inv_i
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DEPTH-1:0] vld_q;
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [DEPTH-1:0] match;

    // Compare each entry against the lookup tag
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (tag_q[g] == look_tag_i);
    end

    // Select the data of the matching entry
    always_comb begin
        hit_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) hit_data_o = hit_data_o | data_q[i];
        end
    end

    assign hit_o = |match;

    // Update valid bits and the replacement pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else if (inv_i) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else if (fill_i) begin
            vld_q[ptr_q] <= 1'b1;
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    // Write the tag and data of the entry being filled
    always_ff @(posedge clk) begin
        if (fill_i && !inv_i) begin
            tag_q[ptr_q] <= fill_tag_i;
            data_q[ptr_q] <= fill_data_i;
        end
    end

    // R10: an invalidate leaves no valid entry behind
    a_r10_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inv_i |=> (vld_q == '0));

    // R9: at most one entry matches any tag
    a_r9_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R9: a fill sets exactly one more valid bit unless the set is full
    a_r9_fill_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && !inv_i && !(&vld_q)) |=> ($countones(vld_q) == $countones($past(vld_q)) + 1));

endmodule

// File: rtl/aprm_walker.sv
// Lookup controller: checks the aperture, range and enable, then probes the
// cache. On a miss it fetches one table word and decodes it.
// Responds one cycle after a decision or after read data arrives.
// Only one fetch is outstanding. Assumes read data arrives exactly once
// per request, with mem_rvalid as a single-cycle strobe.
module aprm_walker
    import aprm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int APER_BITS = 4,
    parameter int PAGE_SHIFT = 12
) (
    input logic clk,
    input logic rst_n,
    input logic [APER_BITS-1:0] aper_sel_i,
    input logic [ADDR_W-PAGE_SHIFT-1:0] tbl_ppn_i,
    input logic [PAGE_SHIFT-1:0] page_cnt_i,
    input logic en_i,
    input logic rst_cmd_i,
    input logic lk_valid_i,
    input logic [ADDR_W-1:0] lk_addr_i,
    output logic lk_ready_o,
    output logic rsp_valid_o,
    output logic rsp_fault_o,
    output logic [ADDR_W-1:0] rsp_paddr_o,
    output logic mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input logic mem_rvalid_i,
    input logic [31:0] mem_rdata_i,
    output logic [ADDR_W-APER_BITS-PAGE_SHIFT-1:0] look_tag_o,
    input logic hit_i,
    input logic [ADDR_W-PAGE_SHIFT-1:0] hit_ppn_i,
    output logic fill_o,
    output logic [ADDR_W-APER_BITS-PAGE_SHIFT-1:0] fill_tag_o,
    output logic [ADDR_W-PAGE_SHIFT-1:0] fill_ppn_o
);

    localparam int IDX_W = ADDR_W - APER_BITS - PAGE_SHIFT;
    localparam int PPN_W = ADDR_W - PAGE_SHIFT;

    typedef enum logic {W_IDLE, W_FETCH} wstate_e;

    wstate_e state_q;
    logic [IDX_W-1:0] idx;
    logic [PAGE_SHIFT-1:0] off;
    logic in_aper, in_range, accept, reject;
    logic [IDX_W-1:0] idx_q;
    logic [PAGE_SHIFT-1:0] off_q;
    logic [ADDR_W-1:0] maddr_q;
    logic [31:0] entry;
    logic ent_ok;
    logic unused_entry;

    // Split the lookup address and classify it
    always_comb begin
        idx = lk_addr_i[PAGE_SHIFT +: IDX_W];
        off = lk_addr_i[PAGE_SHIFT-1:0];
        in_aper = lk_addr_i[ADDR_W-1 -: APER_BITS] == aper_sel_i;
        in_range = ({{IDX_W{1'b0}}, idx} < {{IDX_W{1'b0}}, page_cnt_i});
        accept = lk_valid_i && (state_q == W_IDLE);
        reject = !en_i || !in_aper || !in_range;
    end

    // Decode the fetched little-endian table word
    always_comb begin
        entry = le_word(mem_rdata_i);
        ent_ok = entry[0];
    end

    assign unused_entry = ^entry[PAGE_SHIFT-1:1];

    // Fetch state, response registers and the latched request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            rsp_valid_o <= 1'b0;
            rsp_fault_o <= 1'b0;
            rsp_paddr_o <= '0;
            idx_q <= '0;
            off_q <= '0;
            maddr_q <= '0;
        end else begin
            rsp_valid_o <= 1'b0;
            unique case (state_q)
                W_IDLE: begin
                    if (accept) begin
                        if (reject) begin
                            rsp_valid_o <= 1'b1;
                            rsp_fault_o <= 1'b1;
                            rsp_paddr_o <= '0;
                        end else if (hit_i) begin
                            rsp_valid_o <= 1'b1;
                            rsp_fault_o <= 1'b0;
                            rsp_paddr_o <= {hit_ppn_i, off};
                        end else begin
                            state_q <= W_FETCH;
                            idx_q <= idx;
                            off_q <= off;
                            maddr_q <= {tbl_ppn_i, {PAGE_SHIFT{1'b0}}}
                                       + (ADDR_W'(idx) << 2);
                        end
                    end
                end
                W_FETCH: begin
                    if (rst_cmd_i) begin
                        state_q <= W_IDLE;
                        rsp_valid_o <= 1'b1;
                        rsp_fault_o <= 1'b1;
                        rsp_paddr_o <= '0;
                    end else if (mem_rvalid_i) begin
                        state_q <= W_IDLE;
                        rsp_valid_o <= 1'b1;
                        rsp_fault_o <= !(ent_ok && en_i);
                        rsp_paddr_o <= (ent_ok && en_i)
                            ? {entry[31 -: PPN_W], off_q} : '0;
                    end
                end
                default: state_q <= W_IDLE;
            endcase
        end
    end

    assign lk_ready_o = (state_q == W_IDLE);
    assign mem_req_o = (state_q == W_FETCH);
    assign mem_addr_o = maddr_q;
    assign look_tag_o = idx;
    assign fill_o = (state_q == W_FETCH) && mem_rvalid_i && !rst_cmd_i
                    && en_i && ent_ok;
    assign fill_tag_o = idx_q;
    assign fill_ppn_o = entry[31 -: PPN_W];

    // R2: a disabled lookup never starts a read
    a_r2_no_fetch_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !en_i) |=> (!mem_req_o && rsp_valid_o && rsp_fault_o));

    // R4: an index past the table end faults at once
    a_r4_range_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && en_i && in_aper && !in_range) |=> (rsp_valid_o && rsp_fault_o && !mem_req_o));

    // R5: a pending read holds its request and address
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rvalid_i && !rst_cmd_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R11: a reset command aborts a pending fetch with a fault
    a_r11_abort_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && rst_cmd_i) |=> (!mem_req_o && rsp_valid_o && rsp_fault_o));

endmodule

// File: rtl/aperture_remap.sv
// Top of the graphics aperture address remapper.
// Connects the configuration block, the lookup walker and the cache.
// Invalidate and reset commands both clear the cache.
// Assumes a single requester on the lookup port and a single memory target.
module aperture_remap
    import aprm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int APER_BITS = 4,
    parameter int PAGE_SHIFT = 12,
    parameter int CACHE_DEPTH = 8
) (
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic [1:0] cfg_sel,
    input logic [31:0] cfg_wdata,
    input logic lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    output logic lk_ready,
    output logic rsp_valid,
    output logic rsp_fault,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input logic mem_rvalid,
    input logic [31:0] mem_rdata,
    output logic flush_done,
    output logic shut_done
);

    localparam int IDX_W = ADDR_W - APER_BITS - PAGE_SHIFT;
    localparam int PPN_W = ADDR_W - PAGE_SHIFT;

    logic [APER_BITS-1:0] aper_sel;
    logic [PPN_W-1:0] tbl_ppn;
    logic [PAGE_SHIFT-1:0] page_cnt;
    logic en, inv_cmd, rst_cmd;
    logic [IDX_W-1:0] look_tag, fill_tag;
    logic hit, fill;
    logic [PPN_W-1:0] hit_ppn, fill_ppn;

    aprm_cfg #(
        .ADDR_W(ADDR_W), .APER_BITS(APER_BITS), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .aper_sel_o(aper_sel), .tbl_ppn_o(tbl_ppn), .page_cnt_o(page_cnt),
        .en_o(en), .inv_cmd_o(inv_cmd), .rst_cmd_o(rst_cmd),
        .flush_done_o(flush_done), .shut_done_o(shut_done)
    );

    aprm_walker #(
        .ADDR_W(ADDR_W), .APER_BITS(APER_BITS), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_walk (
        .clk(clk), .rst_n(rst_n),
        .aper_sel_i(aper_sel), .tbl_ppn_i(tbl_ppn), .page_cnt_i(page_cnt),
        .en_i(en), .rst_cmd_i(rst_cmd),
        .lk_valid_i(lk_valid), .lk_addr_i(lk_addr), .lk_ready_o(lk_ready),
        .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
        .look_tag_o(look_tag), .hit_i(hit), .hit_ppn_i(hit_ppn),
        .fill_o(fill), .fill_tag_o(fill_tag), .fill_ppn_o(fill_ppn)
    );

    aprm_tcache #(
        .DEPTH(CACHE_DEPTH), .TAG_W(IDX_W), .DATA_W(PPN_W)
    ) u_cache (
        .clk(clk), .rst_n(rst_n),
        .look_tag_i(look_tag), .hit_o(hit), .hit_data_o(hit_ppn),
        .fill_i(fill), .fill_tag_i(fill_tag), .fill_data_i(fill_ppn),
        .inv_i(inv_cmd || rst_cmd)
    );

    // R8: a response never coincides with an outstanding read
    a_r8_no_rsp_while_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !rsp_valid);

endmodule

// File: tb/aperture_remap_bench.sv
// Directed bench for the aperture remapper: one task per scenario.
module aperture_remap_bench;

    localparam logic [31:0] C_INV = 32'h0000_0001;
    localparam logic [31:0] C_EN = 32'h0000_0100;
    localparam logic [31:0] C_RST = 32'h0001_0000;
    localparam logic [31:0] TBL_BASE = 32'h0012_3000;
    localparam int PAGES = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic lk_ready, rsp_valid, rsp_fault;
    logic [31:0] rsp_paddr;
    logic mem_req;
    logic [31:0] mem_addr;
    logic mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic flush_done, shut_done;

    int checks = 0;
    int errors = 0;
    logic last_flush, last_shut;

    always #5 clk = ~clk;

    aperture_remap u_aperture_remap (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ready(lk_ready),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .flush_done(flush_done), .shut_done(shut_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act %h exp %h", req, act, exp);
        end
    endtask

    // Page value stored for an index: page number plus valid flag (index 5 invalid)
    function automatic logic [19:0] ppn_of(input int idx);
        return 20'h80000 + 20'(idx * 17);
    endfunction

    function automatic logic [31:0] raw_of(input int idx);
        logic [31:0] v;
        v = {ppn_of(idx), 11'h0, (idx != 5)};
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] ap_addr(input int idx, input logic [11:0] off);
        return {4'h3, 16'(idx), off};
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        last_flush = flush_done;
        last_shut = shut_done;
    endtask

    // Answer one pending read after lat cycles of request
    task automatic serve(input string req, input int lat);
        int idx;
        idx = int'((mem_addr - TBL_BASE) >> 2);
        chk(mem_addr[1:0] == 2'b00 && idx >= 0 && idx < PAGES, req, mem_addr, TBL_BASE);
        for (int i = 1; i < lat; i++) begin
            @(negedge clk);
            chk(mem_req == 1'b1, "R5 request held", {31'b0, mem_req}, 32'h1);
        end
        mem_rdata = raw_of(idx);
        mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
    endtask

    task automatic lookup(input string req, input logic [31:0] addr, input int lat,
                          input bit exp_fault, input logic [31:0] exp_pa,
                          input bit exp_mem);
        bit got, used;
        logic f;
        logic [31:0] pa;
        logic [31:0] exp_maddr;
        got = 0; used = 0; f = 0; pa = '0;
        exp_maddr = TBL_BASE + {14'h0, addr[27:12], 2'b00};
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = addr;
        @(negedge clk);
        lk_valid = 1'b0;
        for (int k = 0; k < 16 && !got; k++) begin
            if (rsp_valid) begin
                got = 1; f = rsp_fault; pa = rsp_paddr;
            end else if (mem_req) begin
                used = 1;
                chk(mem_addr == exp_maddr, {req, " R5 read address"}, mem_addr, exp_maddr);
                serve(req, lat);
            end else begin
                @(negedge clk);
            end
        end
        chk(got, {req, " response"}, {31'b0, got}, 32'h1);
        chk(used == exp_mem, {req, " memory read"}, {31'b0, used}, {31'b0, exp_mem});
        chk(f == exp_fault, {req, " fault"}, {31'b0, f}, {31'b0, exp_fault});
        if (!exp_fault) chk(pa == exp_pa, {req, " paddr"}, pa, exp_pa);
    endtask

    task automatic t_reset;
        chk(lk_ready == 1'b1, "R1 lk_ready", {31'b0, lk_ready}, 32'h1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        chk(mem_req == 1'b0, "R1 mem_req", {31'b0, mem_req}, 32'h0);
        chk(flush_done == 1'b0 && shut_done == 1'b0, "R1 pulses",
            {30'b0, flush_done, shut_done}, 32'h0);
    endtask

    task automatic t_disabled;
        cfg_write(2'd0, 32'h3ABC_DEF0);
        cfg_write(2'd1, TBL_BASE | PAGES);
        lookup("R2 disabled", ap_addr(0, 12'h010), 1, 1'b1, '0, 1'b0);
    endtask

    task automatic t_aperture;
        cfg_write(2'd2, C_EN);
        lookup("R3 outside window", 32'h4000_1000, 1, 1'b1, '0, 1'b0);
        lookup("R6 first fetch (R3 low bits ignored)", ap_addr(0, 12'hABC), 3,
               1'b0, {ppn_of(0), 12'hABC}, 1'b1);
    endtask

    task automatic t_hit;
        lookup("R8 cached page", ap_addr(0, 12'h123), 1, 1'b0, {ppn_of(0), 12'h123}, 1'b0);
    endtask

    task automatic t_invalid_entry;
        lookup("R7 invalid entry", ap_addr(5, 12'h0), 2, 1'b1, '0, 1'b1);
        lookup("R7 invalid not cached", ap_addr(5, 12'h4), 1, 1'b1, '0, 1'b1);
    endtask

    task automatic t_range;
        lookup("R4 index equals count", ap_addr(PAGES, 12'h0), 1, 1'b1, '0, 1'b0);
        lookup("R4 last index", ap_addr(PAGES - 1, 12'hFFF), 4, 1'b0,
               {ppn_of(PAGES - 1), 12'hFFF}, 1'b1);
    endtask

    task automatic t_inval_and_rr;
        cfg_write(2'd2, C_EN | C_INV);
        lookup("R10 miss after invalidate", ap_addr(0, 12'h1), 1, 1'b0,
               {ppn_of(0), 12'h1}, 1'b1);
        for (int i = 1; i <= 9; i++) begin
            if (i != 5)
                lookup("R9 fill", ap_addr(i, 12'h2), 1, 1'b0, {ppn_of(i), 12'h2}, 1'b1);
        end
        lookup("R9 second page kept", ap_addr(1, 12'h3), 1, 1'b0, {ppn_of(1), 12'h3}, 1'b0);
        lookup("R9 first page evicted", ap_addr(0, 12'h3), 1, 1'b0, {ppn_of(0), 12'h3}, 1'b1);
    endtask

    task automatic t_reset_abort;
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = ap_addr(1, 12'h7);
        @(negedge clk);
        lk_valid = 1'b0;
        chk(mem_req == 1'b1, "R11 miss fetches", {31'b0, mem_req}, 32'h1);
        cfg_wr = 1'b1; cfg_sel = 2'd2; cfg_wdata = C_EN | C_RST;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(rsp_valid && rsp_fault, "R11 abort fault", {30'b0, rsp_valid, rsp_fault}, 32'h3);
        chk(mem_req == 1'b0, "R11 request dropped", {31'b0, mem_req}, 32'h0);
        mem_rdata = raw_of(1);
        mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk(rsp_valid == 1'b0, "R11 stale data ignored", {31'b0, rsp_valid}, 32'h0);
        lookup("R11 cache cleared", ap_addr(2, 12'h8), 1, 1'b0, {ppn_of(2), 12'h8}, 1'b1);
    endtask

    task automatic t_flush_seq;
        cfg_write(2'd2, C_EN | C_INV);
        chk(!last_flush, "R12 step1 quiet", {31'b0, last_flush}, 32'h0);
        cfg_write(2'd2, C_EN);
        chk(!last_flush, "R12 step2 quiet", {31'b0, last_flush}, 32'h0);
        cfg_write(2'd2, C_EN | C_RST);
        chk(!last_flush, "R12 step3 quiet", {31'b0, last_flush}, 32'h0);
        cfg_write(2'd2, C_EN);
        chk(last_flush, "R12 flush recognised", {31'b0, last_flush}, 32'h1);
        @(negedge clk);
        chk(!flush_done, "R12 single pulse", {31'b0, flush_done}, 32'h0);
        cfg_write(2'd2, C_EN | C_INV);
        cfg_write(2'd2, C_EN | C_RST);
        cfg_write(2'd2, C_EN);
        chk(!last_flush, "R12 wrong order", {31'b0, last_flush}, 32'h0);
    endtask

    task automatic t_shutdown;
        cfg_write(2'd2, C_EN | C_INV);
        chk(!last_shut, "R13 first write quiet", {31'b0, last_shut}, 32'h0);
        cfg_write(2'd2, C_RST);
        chk(last_shut, "R13 shutdown recognised", {31'b0, last_shut}, 32'h1);
        lookup("R13 disabled after shutdown", ap_addr(2, 12'h9), 1, 1'b1, '0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired act 0 exp 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_aperture();
        t_hit();
        t_invalid_entry();
        t_range();
        t_inval_and_rr();
        t_reset_abort();
        t_flush_seq();
        t_shutdown();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule